// File: doc/BRIEF.md
# Video Window Scale Controller

This block decides, sample by sample and line by line, which parts of an incoming video field are kept, so that a window of XS source pixels by YS source lines is reduced to XD by YD destination pixels and lines. Each line is framed by a line-active reference; a vertical sync edge starts a new field. Downstream data-path logic, such as filters or a frame-buffer writer, uses the keep strobes to drop samples and lines, and uses the line-increment pulse to advance its line address.

A field holds two programmable vertical bands. In the scaling band, which starts at line YO and spans YS lines, both directions are decimated with an error-accumulator (Bresenham) rule. In the bypass band, which starts at line BS and spans BC lines, every active sample of the line passes with no windowing and no decimation. Where the bands overlap, the scaling band wins. A line whose reference drops early simply ends: the next line restarts its sample count and its horizontal accumulator.

Top module: `vscale_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, pix_keep, line_keep, in_bypass, in_scale and line_inc are all 0.
- R2: Samples of a line are the cycles with pix_en=1 while href=1, indexed from 0 at the rising edge of href. On a scaled line only samples with index p where XO <= p < XO+XS can be kept. Samples outside that window are never kept.
- R3: On a kept scaled line, the k-th window sample (k from 1) is kept when floor(k*XD/XS) > floor((k-1)*XD/XS). XD >= XS keeps every window sample, and XD = 0 keeps none. pix_keep is high for one cycle, in the cycle after the sample.
- R4: When href falls before the window is complete, the line ends at once. The next line restarts at sample index 0 with a cleared horizontal accumulator.
- R5: A rising edge of vsync makes the following line line 0. Each falling edge of href advances the line index by one.
- R6: in_scale is 1 during line L when YO <= L < YO+YS. The flag is updated in the cycle after the vsync rise or href fall that starts the line.
- R7: For the j-th line of the scaling band (j from 1), line_keep is 1 when floor(j*YD/YS) > floor((j-1)*YD/YS). YD >= YS keeps every band line.
- R8: in_bypass is 1 during line L when BS <= L < BS+BC and L is not in the scaling band. On such a line line_keep is 1 and every sample is kept, whatever XO, XS and XD hold.
- R9: A line that lies in both bands is treated only as a scaling line: in_bypass is 0 and R2, R3 and R7 apply.
- R10: line_inc is a one-cycle pulse, raised in the cycle after the falling edge of href that ends a line whose line_keep was 1.
- R11: On a line in neither band, and on a scaling line with line_keep 0, no sample is kept and line_inc stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Sample-valid enable |
| href | input | 1 | Line-active reference |
| vsync | input | 1 | Vertical sync, rising edge starts a field |
| cfg_xo | input | 10 | Horizontal offset in samples |
| cfg_xs | input | 10 | Source window width |
| cfg_xd | input | 10 | Destination width |
| cfg_yo | input | 10 | First line of the scaling band |
| cfg_ys | input | 10 | Source line count of the scaling band |
| cfg_yd | input | 10 | Destination line count |
| cfg_bs | input | 10 | First line of the bypass band |
| cfg_bc | input | 10 | Line count of the bypass band |
| pix_keep | output | 1 | Keep strobe for the previous cycle's sample |
| line_keep | output | 1 | Current line is passed |
| in_bypass | output | 1 | Current line is in the bypass band |
| in_scale | output | 1 | Current line is in the scaling band |
| line_inc | output | 1 | End-of-kept-line pulse |

## Verification
The bench sweeps small ratios in both directions, including XD = 0, XD = XS, XD > XS and offsets that push the window past short lines. An accumulator that is not cleared per line would shift the keep positions of the next line. A wrong window compare would keep one sample too many or too few at either edge. The overlap and bypass fields catch a design that gives the bands the wrong priority, or that applies the horizontal window to bypass lines and so drops their outer samples. An off-by-one in the line index after vsync would move every band by a whole line, and an extra pulse on a dropped line would show up on line_inc.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
    parameter int unsigned VSC_W = 10;

    typedef enum logic [1:0] {
        BAND_NONE   = 2'd0,
        BAND_BYPASS = 2'd1,
        BAND_SCALE  = 2'd2
    } band_e;
endpackage

// File: rtl/vsc_ratio.sv
// Single step of an error accumulator: keep when the running sum wraps.
module vsc_ratio #(
    parameter int unsigned W = 10
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] dst,
    input  logic [W-1:0] src,
    output logic         keep,
    output logic [W-1:0] acc_nx
);
    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, acc} + {1'b0, dst};
        if (dst >= src) begin
            keep   = 1'b1;
            acc_nx = '0;
        end else if (sum >= {1'b0, src}) begin
            keep   = 1'b1;
            acc_nx = W'(sum - {1'b0, src});
        end else begin
            keep   = 1'b0;
            acc_nx = sum[W-1:0];
        end
    end
endmodule

// File: rtl/vsc_hgate.sv
// Per-sample keep decision inside one line.
module vsc_hgate #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample,
    input  logic         line_start,
    input  logic         en_bypass,
    input  logic         en_scaled,
    input  logic [W-1:0] xo,
    input  logic [W-1:0] xs,
    input  logic [W-1:0] xd,
    output logic         pix_keep
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] acc;
        logic         keep;
    } hstate_t;

    hstate_t st_d, st_q;
    logic [W-1:0] idx;
    logic [W-1:0] acc_base;
    logic         in_win;
    logic         r_keep;
    logic [W-1:0] r_acc;

    assign idx      = line_start ? '0 : st_q.cnt;
    assign acc_base = line_start ? '0 : st_q.acc;
    assign in_win   = ({1'b0, idx} >= {1'b0, xo}) &&
                      ({1'b0, idx} <  ({1'b0, xo} + {1'b0, xs}));

    vsc_ratio #(.W(W)) u_hratio (
        .acc    (acc_base),
        .dst    (xd),
        .src    (xs),
        .keep   (r_keep),
        .acc_nx (r_acc)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = idx;
        st_d.acc  = acc_base;
        st_d.keep = 1'b0;
        if (sample) begin
            st_d.cnt = (idx == CNT_MAX) ? idx : idx + 1'b1;
            if (en_bypass) begin
                st_d.keep = 1'b1;
            end else if (en_scaled && in_win) begin
                st_d.acc  = r_acc;
                st_d.keep = r_keep;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_keep = st_q.keep;

    // R8: a sample on a bypass line is always kept one cycle later
    a_r8_bypass_keeps_all: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && en_bypass) |=> pix_keep);
endmodule

// File: rtl/vsc_vgate.sv
// Line index, band membership and vertical keep decision.
module vsc_vgate #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_start,
    input  logic         line_end,
    input  logic [W-1:0] yo,
    input  logic [W-1:0] ys,
    input  logic [W-1:0] yd,
    input  logic [W-1:0] bs,
    input  logic [W-1:0] bc,
    output logic         in_bypass,
    output logic         in_scale,
    output logic         line_keep,
    output logic         line_inc
);
    import vsc_pkg::*;

    localparam logic [W-1:0] LINE_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] line;
        logic [W-1:0] acc;
        band_e        band;
        logic         vkeep;
        logic         inc;
    } vstate_t;

    vstate_t st_d, st_q;
    logic [W-1:0] nl;
    logic [W-1:0] acc_base;
    logic         nl_scale, nl_bypass, cur_keep;
    logic         r_keep;
    logic [W-1:0] r_acc;

    assign nl        = frame_start ? '0 :
                       (st_q.line == LINE_MAX) ? st_q.line : st_q.line + 1'b1;
    assign acc_base  = frame_start ? '0 : st_q.acc;
    assign nl_scale  = ({1'b0, nl} >= {1'b0, yo}) &&
                       ({1'b0, nl} <  ({1'b0, yo} + {1'b0, ys}));
    assign nl_bypass = ({1'b0, nl} >= {1'b0, bs}) &&
                       ({1'b0, nl} <  ({1'b0, bs} + {1'b0, bc}));
    assign cur_keep  = (st_q.band == BAND_BYPASS) ||
                       ((st_q.band == BAND_SCALE) && st_q.vkeep);

    vsc_ratio #(.W(W)) u_vratio (
        .acc    (acc_base),
        .dst    (yd),
        .src    (ys),
        .keep   (r_keep),
        .acc_nx (r_acc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.inc = line_end && !frame_start && cur_keep;
        if (frame_start || line_end) begin
            st_d.line = nl;
            st_d.acc  = acc_base;
            if (nl_scale) begin
                st_d.band  = BAND_SCALE;
                st_d.acc   = r_acc;
                st_d.vkeep = r_keep;
            end else if (nl_bypass) begin
                st_d.band  = BAND_BYPASS;
                st_d.vkeep = 1'b0;
            end else begin
                st_d.band  = BAND_NONE;
                st_d.vkeep = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_bypass = (st_q.band == BAND_BYPASS);
    assign in_scale  = (st_q.band == BAND_SCALE);
    assign line_keep = cur_keep;
    assign line_inc  = st_q.inc;

    // R5: a line end without a new field moves the index up by one (or holds at the top)
    a_r5_line_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && !frame_start) |=>
        ((st_q.line == $past(st_q.line) + 1'b1) || ($past(st_q.line) == LINE_MAX)));
endmodule

// File: rtl/vscale_ctrl.sv
module vscale_ctrl #(
    parameter int unsigned W = vsc_pkg::VSC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pix_en,
    input  logic         href,
    input  logic         vsync,
    input  logic [W-1:0] cfg_xo,
    input  logic [W-1:0] cfg_xs,
    input  logic [W-1:0] cfg_xd,
    input  logic [W-1:0] cfg_yo,
    input  logic [W-1:0] cfg_ys,
    input  logic [W-1:0] cfg_yd,
    input  logic [W-1:0] cfg_bs,
    input  logic [W-1:0] cfg_bc,
    output logic         pix_keep,
    output logic         line_keep,
    output logic         in_bypass,
    output logic         in_scale,
    output logic         line_inc
);
    typedef struct packed {
        logic href;
        logic vs;
    } edge_t;

    edge_t ed_d, ed_q;
    logic  href_rise, href_fall, vs_rise, sample;

    always_comb begin
        ed_d.href = href;
        ed_d.vs   = vsync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ed_q <= '0;
        else        ed_q <= ed_d;
    end

    assign href_rise = href && !ed_q.href;
    assign href_fall = !href && ed_q.href;
    assign vs_rise   = vsync && !ed_q.vs;
    assign sample    = pix_en && href;

    vsc_vgate #(.W(W)) u_vgate (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (vs_rise),
        .line_end    (href_fall),
        .yo          (cfg_yo),
        .ys          (cfg_ys),
        .yd          (cfg_yd),
        .bs          (cfg_bs),
        .bc          (cfg_bc),
        .in_bypass   (in_bypass),
        .in_scale    (in_scale),
        .line_keep   (line_keep),
        .line_inc    (line_inc)
    );

    vsc_hgate #(.W(W)) u_hgate (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample     (sample),
        .line_start (href_rise),
        .en_bypass  (in_bypass),
        .en_scaled  (in_scale && line_keep),
        .xo         (cfg_xo),
        .xs         (cfg_xs),
        .xd         (cfg_xd),
        .pix_keep   (pix_keep)
    );

    // R3: a keep strobe always follows an actual sample
    a_r3_keep_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        pix_keep |-> $past(pix_en && href));

    // R11: nothing is kept on a line that is not passed
    a_r11_keep_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
        pix_keep |-> $past(line_keep));

    // R10: the line-increment output is a single-cycle pulse
    a_r10_inc_single: assert property (@(posedge clk) disable iff (!rst_n)
        line_inc |=> !line_inc);
endmodule

// File: tb/tb_vscale_ctrl.sv
`timescale 1ns/1ps
module tb_vscale_ctrl;
    logic       clk = 1'b0;
    logic       rst_n, pix_en, href, vsync;
    logic [9:0] cfg_xo, cfg_xs, cfg_xd, cfg_yo, cfg_ys, cfg_yd, cfg_bs, cfg_bc;
    logic       pix_keep, line_keep, in_bypass, in_scale, line_inc;

    always #2 clk = ~clk;

    vscale_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .href(href), .vsync(vsync),
        .cfg_xo(cfg_xo), .cfg_xs(cfg_xs), .cfg_xd(cfg_xd),
        .cfg_yo(cfg_yo), .cfg_ys(cfg_ys), .cfg_yd(cfg_yd),
        .cfg_bs(cfg_bs), .cfg_bc(cfg_bc),
        .pix_keep(pix_keep), .line_keep(line_keep), .in_bypass(in_bypass),
        .in_scale(in_scale), .line_inc(line_inc)
    );

    int    n_chk = 0, n_err = 0;
    bit    done = 1'b0;
    string cur_req = "R3";
    int    lb = 0, p = 0;
    bit    h_prev = 1'b0, vs_prev = 1'b0;
    bit    exp_pk = 1'b0, exp_li = 1'b0;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d (line %0d)", req, act, exp, lb);
        end
    endtask

    function automatic bit ratio_keep(int k, int d, int s);
        if (d >= s) return 1'b1;
        return ((k * d) / s) > (((k - 1) * d) / s);
    endfunction

    function automatic bit is_sc(int l);
        return l >= int'(cfg_yo) && l < int'(cfg_yo) + int'(cfg_ys);
    endfunction
    function automatic bit is_by(int l);
        return !is_sc(l) && l >= int'(cfg_bs) && l < int'(cfg_bs) + int'(cfg_bc);
    endfunction
    function automatic bit vk(int l);
        return is_sc(l) && ratio_keep(l - int'(cfg_yo) + 1, int'(cfg_yd), int'(cfg_ys));
    endfunction
    function automatic bit lk(int l);
        return vk(l) || is_by(l);
    endfunction

    task automatic drive(bit h, bit pe, bit vs);
        @(negedge clk);
        check(cur_req, pix_keep, exp_pk);
        check("R10", line_inc, exp_li);
        if (h && h_prev) begin
            check("R5 R6", in_scale, is_sc(lb));
            check("R8", in_bypass, is_by(lb));
            check("R7", line_keep, lk(lb));
        end
        href = h; pix_en = pe; vsync = vs;
        exp_li = 1'b0;
        if (vs && !vs_prev) lb = 0;
        if (h_prev && !h) begin
            exp_li = lk(lb);
            lb++;
        end
        if (h && !h_prev) p = 0;
        exp_pk = 1'b0;
        if (h && pe) begin
            if (is_by(lb)) exp_pk = 1'b1;
            else if (vk(lb) && p >= int'(cfg_xo) && p < int'(cfg_xo) + int'(cfg_xs))
                exp_pk = ratio_keep(p - int'(cfg_xo) + 1, int'(cfg_xd), int'(cfg_xs));
            p++;
        end
        h_prev = h; vs_prev = vs;
    endtask

    task automatic field(int nl, int na, bit gaps);
        drive(0, 0, 1); drive(0, 0, 0); drive(0, 0, 0);
        for (int l = 0; l < nl; l++) begin
            for (int i = 0; i < (gaps ? 2 * na : na); i++)
                drive(1, gaps ? (i % 2 == 0) : 1'b1, 0);
            drive(0, 0, 0); drive(0, 0, 0); drive(0, 0, 0);
        end
    endtask

    task automatic set_cfg(int xo, int xs, int xd, int yo, int ys, int yd, int bs, int bc);
        cfg_xo = 10'(xo); cfg_xs = 10'(xs); cfg_xd = 10'(xd);
        cfg_yo = 10'(yo); cfg_ys = 10'(ys); cfg_yd = 10'(yd);
        cfg_bs = 10'(bs); cfg_bc = 10'(bc);
    endtask

    initial begin
        rst_n = 1'b0; pix_en = 1'b0; href = 1'b0; vsync = 1'b0;
        set_cfg(0, 4, 2, 0, 1, 1, 0, 0);
        repeat (5) @(negedge clk);
        check("R1", {pix_keep, line_keep, in_bypass, in_scale, line_inc}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {pix_keep, line_keep, in_bypass, in_scale, line_inc}, 0);

        // R2 R3: horizontal sweep on always-kept scaled lines
        cur_req = "R2 R3";
        for (int xs = 1; xs <= 6; xs++)
            for (int xd = 0; xd <= 7; xd++)
                for (int xo = 0; xo <= 2; xo++) begin
                    set_cfg(xo, xs, xd, 0, 2, 2, 0, 0);
                    field(2, xo + xs + 2, (xd % 2) == 1);
                end

        // R5 R6 R7: vertical sweep
        cur_req = "R7";
        for (int ys = 1; ys <= 6; ys++)
            for (int yd = 0; yd <= 6; yd++)
                for (int yo = 0; yo <= 2; yo++) begin
                    set_cfg(1, 3, 2, yo, ys, yd, 0, 0);
                    field(yo + ys + 2, 5, 1'b0);
                end

        // R4: lines that end before the window completes
        cur_req = "R4";
        set_cfg(1, 6, 3, 0, 4, 4, 0, 0);
        field(3, 4, 1'b0);
        field(3, 3, 1'b1);
        field(2, 9, 1'b0);

        // R8: bypass band passes every sample
        cur_req = "R8";
        set_cfg(2, 2, 1, 20, 2, 1, 1, 2);
        field(5, 6, 1'b1);

        // R9: overlapping bands, scaling wins
        cur_req = "R9";
        set_cfg(1, 4, 2, 1, 2, 1, 0, 4);
        field(6, 6, 1'b0);

        // R11: lines outside both bands and dropped scaled lines
        cur_req = "R11";
        set_cfg(0, 4, 4, 3, 3, 1, 7, 0);
        field(8, 5, 1'b0);

        drive(0, 0, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule